// File: doc/BRIEF.md
# Target In-Band Event Request Controller

This unit sits inside an I3C target and lets software ask the bus controller for attention. Software asks either for an in-band interrupt (with one mandatory data byte and optionally more payload from the transmit buffer) or for a hot-join. It does so by writing a small byte-wide register port. The unit checks the request against the live bus state before letting it out. That state is the bus-busy flag, dynamic-address validity, and the two enable bits the controller can clear.

A request that passes the checks is held on a simple bus-side handshake until the bus logic reports ACK or NACK. A request that fails any check is never started. In every case the unit posts a two-bit outcome code and raises an interrupt. Software clears the interrupt and the outcome by writing ones to the status bits.

Only one request can be in flight. While it is waiting, software can withdraw it by writing normal mode to the event-select field. Any other event-select write is dropped until the request finishes.

Top module: `inband_evt_ctrl`

## Requirements
- R1: After synchronous reset, `irq` and `req_valid` are low and the three register addresses all read 0x00. Address 0 is control; address 1 is the data byte; address 2 is status. Address 3 always reads 0x00.
- R2: In the control register, bits [1:0] are the event select and bit 2 is the extended-payload flag. Event select values are: 0 normal, 1 interrupt, 2 role request, 3 hot-join. Writing select 1 while idle starts an interrupt when all of these hold: the bus is not busy, a dynamic address is valid, and interrupts are not disabled. `req_valid` then rises the following cycle with `req_kind`=1, `req_mdb` equal to the data byte, and `req_ext` equal to the flag.
- R3: Select 3 (hot-join) starts only when no dynamic address is valid, hot-join is not disabled, and the bus is idle.
- R4: A request written while `bus_busy` is high does not start. It posts outcome 1 (not sent) and raises `irq` on the next cycle.
- R5: An interrupt request does not start, and posts outcome 1, when either the dynamic address is invalid or interrupts are disabled.
- R6: A role request (select 2) never starts and always posts outcome 1.
- R7: If the extended flag is set and the upper three bits of the data byte equal 5 (pending-read group), an interrupt request posts outcome 1 and does not start. If the flag is clear, the same byte is accepted.
- R8: An in-flight request ends on the cycle `bus_done` is sampled high. The cycle after, `req_valid` is low, `irq` is high, and the outcome field (status bits [5:4]) reads 3 if `bus_ack` was high or 2 if it was low. Status bit 1 (ACK event) is set only for an ACK.
- R9: Status bits are write-one-to-clear. Writing 1 to bit 0 clears `irq` and resets the outcome to 0. Writing 1 to bit 1 clears the ACK-event bit. Zero bits have no effect.
- R10: Writing select 0 while a request is in flight drops `req_valid` on the next cycle and leaves the status unchanged.
- R11: While a request is in flight, control writes with a non-zero select are ignored. `req_kind` and the control readback stay unchanged.
- R12: If `bus_done` and an abort write arrive in the same cycle, the completion is reported.
- R13: Control readback shows the in-flight select and flag. It reads 0 when no request is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| bus_busy | input | 1 | Bus currently busy |
| dyn_addr_valid | input | 1 | A dynamic address is assigned |
| ibi_disabled | input | 1 | Controller has disabled interrupt requests |
| hj_disabled | input | 1 | Controller has disabled hot-join |
| req_valid | output | 1 | Request held toward the bus logic |
| req_kind | output | 2 | Event select of the in-flight request |
| req_mdb | output | 8 | Mandatory data byte of the request |
| req_ext | output | 1 | Extra payload from transmit buffer requested |
| bus_done | input | 1 | Bus logic finished the request |
| bus_ack | input | 1 | Request was acknowledged (with bus_done) |
| irq | output | 1 | Event-complete interrupt |

## Verification
The bench tries each select value against every combination of the gating inputs that should flip the decision. Each gate is toggled alone: bus busy, address valid versus invalid, and each disable bit. This separates a missing check from a check on the wrong kind. The extended-payload rule is tried with the pending-read byte both with and without the flag, and with an ordinary byte with the flag. This shows that the rule depends on both fields together. In-flight requests are ended by ACK, by NACK, by abort, and by abort coinciding with completion. Further writes are attempted while waiting, which separates completion priority and write filtering from the plain path.

// File: rtl/inband_evt_pkg.sv
package inband_evt_pkg;

    localparam int DW      = 8;
    localparam int REG_AW  = 2;
    localparam int SEL_W   = 2;
    localparam int GRP_W   = 3;

    localparam logic [REG_AW-1:0] A_CTRL = 2'd0;
    localparam logic [REG_AW-1:0] A_MDB  = 2'd1;
    localparam logic [REG_AW-1:0] A_STAT = 2'd2;

    localparam int CTRL_EXT_BIT  = 2;
    localparam int STAT_DONE_BIT = 0;
    localparam int STAT_ACK_BIT  = 1;
    localparam int STAT_OUT_LSB  = 4;

    localparam logic [GRP_W-1:0] GRP_PENDING_READ = 3'd5;

    typedef enum logic [SEL_W-1:0] {
        SEL_NONE = 2'd0,
        SEL_IBI  = 2'd1,
        SEL_ROLE = 2'd2,
        SEL_HJ   = 2'd3
    } evt_sel_e;

    typedef enum logic [1:0] {
        OUT_NONE     = 2'd0,
        OUT_NOT_SENT = 2'd1,
        OUT_NACK     = 2'd2,
        OUT_ACK      = 2'd3
    } evt_out_e;

    typedef struct packed {
        evt_sel_e        sel;
        logic            ext;
        logic [DW-1:0]   mdb;
    } evt_req_t;

    typedef struct packed {
        logic busy;
        logic dav;
        logic ibi_off;
        logic hj_off;
    } bus_stat_t;

    // Decides whether a candidate request may leave the unit.
    function automatic logic may_start(evt_req_t r, bus_stat_t s);
        logic ok;
        ok = 1'b0;
        if (!s.busy) begin
            case (r.sel)
                SEL_IBI: ok = s.dav && !s.ibi_off &&
                              !(r.ext && (r.mdb[DW-1 -: GRP_W] == GRP_PENDING_READ));
                SEL_HJ:  ok = !s.dav && !s.hj_off;
                default: ok = 1'b0;
            endcase
        end
        return ok;
    endfunction

endpackage

// File: rtl/inband_evt_regif.sv
module inband_evt_regif
    import inband_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    input  logic              active,
    input  evt_req_t          cur,
    input  logic              done,
    input  logic              ack,
    input  evt_out_e          outcome,
    output logic              ctrl_wr,
    output evt_sel_e          ctrl_sel,
    output logic              ctrl_ext,
    output logic [DW-1:0]     mdb_q,
    output logic              clr_done,
    output logic              clr_ack,
    output logic [DW-1:0]     rd_data
);

    always_ff @(posedge clk) begin
        if (rst)
            mdb_q <= '0;
        else if (wr_en && wr_addr == A_MDB)
            mdb_q <= wr_data;
    end

    always_comb begin
        ctrl_wr  = wr_en && (wr_addr == A_CTRL);
        ctrl_sel = evt_sel_e'(wr_data[SEL_W-1:0]);
        ctrl_ext = wr_data[CTRL_EXT_BIT];
        clr_done = wr_en && (wr_addr == A_STAT) && wr_data[STAT_DONE_BIT];
        clr_ack  = wr_en && (wr_addr == A_STAT) && wr_data[STAT_ACK_BIT];
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL: begin
                if (active) begin
                    rd_data[SEL_W-1:0]    = cur.sel;
                    rd_data[CTRL_EXT_BIT] = cur.ext;
                end
            end
            A_MDB:  rd_data = mdb_q;
            A_STAT: begin
                rd_data[STAT_DONE_BIT]               = done;
                rd_data[STAT_ACK_BIT]                = ack;
                rd_data[STAT_OUT_LSB +: 2]           = outcome;
            end
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/inband_evt_fsm.sv
module inband_evt_fsm
    import inband_evt_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ctrl_wr,
    input  evt_sel_e      ctrl_sel,
    input  logic          ctrl_ext,
    input  logic [DW-1:0] mdb_q,
    input  bus_stat_t     stat,
    input  logic          bus_done,
    input  logic          bus_ack,
    output logic          active,
    output evt_req_t      cur,
    output logic          fin,
    output evt_out_e      fin_code
);

    evt_req_t cand;
    logic     cand_ok;
    logic     new_req;

    always_comb begin
        cand     = '{sel: ctrl_sel, ext: ctrl_ext, mdb: mdb_q};
        cand_ok  = may_start(cand, stat);
        new_req  = !active && ctrl_wr && (ctrl_sel != SEL_NONE);
        fin      = active ? bus_done : (new_req && !cand_ok);
        fin_code = active ? (bus_ack ? OUT_ACK : OUT_NACK) : OUT_NOT_SENT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cur    <= '0;
        end else if (active) begin
            if (bus_done)
                active <= 1'b0;
            else if (ctrl_wr && ctrl_sel == SEL_NONE)
                active <= 1'b0;
        end else if (new_req && cand_ok) begin
            active <= 1'b1;
            cur    <= cand;
        end
    end

    AST_HJ_GATE: assert property (@(posedge clk) disable iff (rst)
        $rose(active) && cur.sel == SEL_HJ |-> $past(!stat.dav && !stat.hj_off && !stat.busy)); // R3

    AST_IBI_GATE: assert property (@(posedge clk) disable iff (rst)
        $rose(active) && cur.sel == SEL_IBI |-> $past(stat.dav && !stat.ibi_off && !stat.busy)); // R5

    AST_NO_ROLE: assert property (@(posedge clk) disable iff (rst)
        active |-> cur.sel != SEL_ROLE); // R6

    AST_KIND_HELD: assert property (@(posedge clk) disable iff (rst)
        active && $past(active) |-> $stable(cur)); // R11

endmodule

// File: rtl/inband_evt_status.sv
module inband_evt_status
    import inband_evt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     fin,
    input  evt_out_e fin_code,
    input  logic     clr_done,
    input  logic     clr_ack,
    output logic     done,
    output logic     ack,
    output evt_out_e outcome
);

    always_ff @(posedge clk) begin
        if (rst) begin
            done    <= 1'b0;
            ack     <= 1'b0;
            outcome <= OUT_NONE;
        end else begin
            if (fin) begin
                done    <= 1'b1;
                outcome <= fin_code;
            end else if (clr_done) begin
                done    <= 1'b0;
                outcome <= OUT_NONE;
            end
            if (fin && fin_code == OUT_ACK)
                ack <= 1'b1;
            else if (clr_ack)
                ack <= 1'b0;
        end
    end

    AST_FLAG_CODE: assert property (@(posedge clk) disable iff (rst)
        done |-> outcome != OUT_NONE); // R9

endmodule

// File: rtl/inband_evt_ctrl.sv
module inband_evt_ctrl
    import inband_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    input  logic              bus_busy,
    input  logic              dyn_addr_valid,
    input  logic              ibi_disabled,
    input  logic              hj_disabled,
    output logic              req_valid,
    output logic [SEL_W-1:0]  req_kind,
    output logic [DW-1:0]     req_mdb,
    output logic              req_ext,
    input  logic              bus_done,
    input  logic              bus_ack,
    output logic              irq
);

    logic      ctrl_wr, ctrl_ext, clr_done, clr_ack;
    evt_sel_e  ctrl_sel;
    logic [DW-1:0] mdb_q;
    logic      active, fin, done, ack;
    evt_req_t  cur;
    evt_out_e  fin_code, outcome;
    bus_stat_t stat;

    assign stat = '{busy: bus_busy, dav: dyn_addr_valid,
                    ibi_off: ibi_disabled, hj_off: hj_disabled};

    inband_evt_regif u_regif (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .active(active), .cur(cur), .done(done), .ack(ack),
        .outcome(outcome), .ctrl_wr(ctrl_wr), .ctrl_sel(ctrl_sel), .ctrl_ext(ctrl_ext),
        .mdb_q(mdb_q), .clr_done(clr_done), .clr_ack(clr_ack), .rd_data(rd_data)
    );

    inband_evt_fsm u_fsm (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_sel(ctrl_sel), .ctrl_ext(ctrl_ext),
        .mdb_q(mdb_q), .stat(stat), .bus_done(bus_done), .bus_ack(bus_ack),
        .active(active), .cur(cur), .fin(fin), .fin_code(fin_code)
    );

    inband_evt_status u_status (
        .clk(clk), .rst(rst), .fin(fin), .fin_code(fin_code), .clr_done(clr_done),
        .clr_ack(clr_ack), .done(done), .ack(ack), .outcome(outcome)
    );

    assign req_valid = active;
    assign req_kind  = cur.sel;
    assign req_mdb   = cur.mdb;
    assign req_ext   = cur.ext;
    assign irq       = done;

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !req_valid && !irq); // R1

    AST_BUSY_BLOCK: assert property (@(posedge clk) disable iff (rst)
        !req_valid && bus_busy && wr_en && wr_addr == A_CTRL && wr_data[1:0] != 2'd0
        |=> !req_valid && irq && outcome == OUT_NOT_SENT); // R4

    AST_ACK_CODE: assert property (@(posedge clk) disable iff (rst)
        req_valid && bus_done && bus_ack |=> !req_valid && irq && ack && outcome == OUT_ACK); // R8

    AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (rst)
        req_valid && !bus_done && wr_en && wr_addr == A_CTRL && wr_data[1:0] == 2'd0
        |=> !req_valid && $stable(irq) && $stable(outcome)); // R10

endmodule

// File: tb/sim_inband_evt_ctrl.sv
module sim_inband_evt_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       bus_busy = 1'b0, dyn_addr_valid = 1'b0, ibi_disabled = 1'b0, hj_disabled = 1'b0;
    logic       req_valid, req_ext, irq;
    logic [1:0] req_kind;
    logic [7:0] req_mdb;
    logic       bus_done = 1'b0, bus_ack = 1'b0;

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag = "R1";
    bit    finished = 1'b0;

    // reference model state
    bit       m_act = 0, m_ext = 0, m_done = 0, m_ack = 0;
    int       m_sel = 0, m_out = 0;
    bit [7:0] m_mdb = 0, m_mdbreg = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    inband_evt_ctrl u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .bus_busy(bus_busy),
        .dyn_addr_valid(dyn_addr_valid), .ibi_disabled(ibi_disabled),
        .hj_disabled(hj_disabled), .req_valid(req_valid), .req_kind(req_kind),
        .req_mdb(req_mdb), .req_ext(req_ext), .bus_done(bus_done), .bus_ack(bus_ack),
        .irq(irq)
    );

    function automatic bit spec_allows(int sel, bit ext, bit [7:0] mdb);
        if (bus_busy) return 0;                                   // R4
        if (sel == 1) return dyn_addr_valid && !ibi_disabled &&
                             !(ext && mdb[7:5] == 3'd5);          // R2 R5 R7
        if (sel == 3) return !dyn_addr_valid && !hj_disabled;     // R3
        return 0;                                                 // R6
    endfunction

    function automatic bit [7:0] exp_read(bit [1:0] a);
        case (a)
            2'd0: return m_act ? {5'd0, m_ext, 2'(m_sel)} : 8'h00;  // R13
            2'd1: return m_mdbreg;
            2'd2: return {2'b00, 2'(m_out), 2'b00, m_ack, m_done};
            default: return 8'h00;
        endcase
    endfunction

    task automatic cmp(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit fin;
        int code;
        bit cw, cd, ca;
        fin = 0; code = 0;
        if (rst) begin
            m_act = 0; m_ext = 0; m_done = 0; m_ack = 0; m_sel = 0; m_out = 0;
            m_mdb = 0; m_mdbreg = 0;
        end else begin
            cw = wr_en && wr_addr == 2'd0;
            cd = wr_en && wr_addr == 2'd2 && wr_data[0];
            ca = wr_en && wr_addr == 2'd2 && wr_data[1];
            if (m_act) begin
                if (bus_done) begin
                    fin = 1; code = bus_ack ? 3 : 2; m_act = 0;   // R8 R12
                end else if (cw && wr_data[1:0] == 2'd0) begin
                    m_act = 0;                                     // R10
                end
            end else if (cw && wr_data[1:0] != 2'd0) begin
                if (spec_allows(int'(wr_data[1:0]), wr_data[2], m_mdbreg)) begin
                    m_act = 1; m_sel = int'(wr_data[1:0]); m_ext = wr_data[2]; m_mdb = m_mdbreg;
                end else begin
                    fin = 1; code = 1;
                end
            end
            if (fin) begin
                m_done = 1; m_out = code;
            end else if (cd) begin
                m_done = 0; m_out = 0;                             // R9
            end
            if (fin && code == 3) m_ack = 1;
            else if (ca) m_ack = 0;
            if (wr_en && wr_addr == 2'd1) m_mdbreg = wr_data;
        end
        #(CLK_PERIOD/4);
        if (!rst && !finished) begin
            cmp("irq", irq, m_done);
            cmp("req_valid", req_valid, m_act);
            cmp("rd_data", rd_data, exp_read(rd_addr));
            if (m_act) begin
                cmp("req_kind", req_kind, m_sel);
                cmp("req_mdb", req_mdb, m_mdb);
                cmp("req_ext", req_ext, m_ext);
            end
        end
    end

    always @(negedge clk) rd_addr <= rd_addr + 2'd1;

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(bit [1:0] a, bit [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic finish_bus(bit a);
        @(negedge clk);
        bus_done = 1; bus_ack = a;
        @(negedge clk);
        bus_done = 0; bus_ack = 0;
    endtask

    task automatic clear_all();
        wr(2'd2, 8'h03);
        tick(4);
    endtask

    initial begin
        tick(4);
        @(negedge clk) rst = 0;
        tag = "R1"; tick(6);

        // R2 R8 accepted interrupt, ACK
        tag = "R2"; dyn_addr_valid = 1;
        wr(2'd1, 8'h3A); wr(2'd0, 8'h01); tick(4);
        tag = "R8"; finish_bus(1); tick(4);
        tag = "R9"; wr(2'd2, 8'h00); tick(4);
        wr(2'd2, 8'h01); tick(4);
        wr(2'd2, 8'h02); tick(4);

        // R8 NACK
        tag = "R8"; wr(2'd0, 8'h01); tick(2); finish_bus(0); tick(4); clear_all();

        // R4 busy
        tag = "R4"; bus_busy = 1; wr(2'd0, 8'h01); tick(3);
        wr(2'd0, 8'h03); tick(3); bus_busy = 0; clear_all();

        // R5 gates
        tag = "R5"; dyn_addr_valid = 0; wr(2'd0, 8'h01); tick(3); clear_all();
        dyn_addr_valid = 1; ibi_disabled = 1; wr(2'd0, 8'h01); tick(3); clear_all();
        ibi_disabled = 0;

        // R3 hot-join
        tag = "R3"; wr(2'd0, 8'h03); tick(3); clear_all();
        dyn_addr_valid = 0; hj_disabled = 1; wr(2'd0, 8'h03); tick(3); clear_all();
        hj_disabled = 0; wr(2'd0, 8'h03); tick(3); finish_bus(1); tick(3); clear_all();
        dyn_addr_valid = 1;

        // R6 role request
        tag = "R6"; wr(2'd0, 8'h02); tick(3); clear_all();

        // R7 pending-read group with extra payload
        tag = "R7"; wr(2'd1, 8'hA5); wr(2'd0, 8'h05); tick(3); clear_all();
        wr(2'd0, 8'h01); tick(3); finish_bus(0); tick(3); clear_all();
        wr(2'd1, 8'h3A); wr(2'd0, 8'h05); tick(3); finish_bus(1); tick(3); clear_all();

        // R10 abort
        tag = "R10"; wr(2'd0, 8'h01); tick(3); wr(2'd0, 8'h00); tick(4);

        // R11 R13 writes ignored while in flight
        tag = "R11"; wr(2'd0, 8'h05); tick(2); wr(2'd0, 8'h03); tick(2);
        wr(2'd0, 8'h02); tick(2); tag = "R13"; tick(4);
        finish_bus(1); tick(3); clear_all();

        // R12 abort coinciding with completion
        tag = "R12"; wr(2'd0, 8'h01); tick(2);
        @(negedge clk);
        wr_en = 1; wr_addr = 2'd0; wr_data = 8'h00; bus_done = 1; bus_ack = 1;
        @(negedge clk);
        wr_en = 0; bus_done = 0; bus_ack = 0;
        tick(4); clear_all();

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule